// File: doc/BRIEF.md
# Cascadable Timer Pair with Count Snapshot

The block holds two 16-bit timer/counters. A lower and an upper half share one small register port. With the pairing bit clear, each half runs on its own. Each half has its own control word, count, period and interrupt flag. With the pairing bit set in the lower control word, the two halves form a single 32-bit timer. The lower half holds the low bits and the upper half holds the high bits. Only the lower control word has any effect in that case, and a match on the combined period raises the upper flag.

A count step can come from three sources. The first is the internal clock-enable input. The second is a synchronised rising edge of an external count input. The third is the internal clock-enable while a gate input is high; in this gated case the falling edge of the gate raises the flag. Each step source feeds a prescaler. A stop-in-idle bit freezes counting while the idle input is high.

Software reads and writes the 32-bit value through a holding register, so that a carry between two 16-bit accesses cannot tear the value. A read of the low count captures the high count into the holding register. A write of the low count loads the high count from the holding register.

Top module: `tpair_timer`

## Requirements
- R1: After reset, both control words, both counts, the holding register and both flags are zero, and both periods are all ones. Register addresses: 0 lower control, 1 upper control, 2 lower count, 3 upper count, 4 lower period, 5 upper period, 6 holding register, 7 flags (bit 0 lower, bit 1 upper).
- R2: The control word bits are: 7 run, 6 gate enable, 5 stop in idle, 4:3 divide code, 2 pairing, 1 external source. In unpaired mode each half with run set advances once per divided step. When its count equals its period it returns to zero and sets its own flag.
- R3: In paired mode the upper count holds bits 31:16 of one 32-bit counter, and a carry out of the lower count increments it.
- R4: In paired mode the upper control word has no effect; the lower control word governs counting.
- R5: In paired mode, when the 32-bit count equals the combined period {upper period, lower period}, the count returns to zero and the upper flag is set; the lower flag stays clear.
- R6: In paired mode a read of the lower count copies the upper count into the holding register on that cycle; a later read of the holding register returns that copy even after the count has moved on.
- R7: In paired mode a write of the lower count loads the upper count from the holding register on the same cycle; a write to address 6 sets the holding register.
- R8: In unpaired mode the holding register ignores writes and reads, and a lower count write leaves the upper count unchanged.
- R9: With the external source selected, the count advances once per rising edge of the external input after a two-stage synchroniser, and the clock-enable input has no effect.
- R10: In gated mode, the count advances on each clock-enable cycle while the synchronised gate is high. A falling gate edge sets the flag.
- R11: With stop in idle set, the count holds while the idle input is high; with it clear, counting goes on through idle.
- R12: Divide codes 0, 1, 2, 3 give ratios 1, 8, 64 and 256. Any write to addresses 0 to 3 clears the prescaler.
- R13: A write of one to a flag bit at address 7 clears that flag. A match or gate event in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal clock-enable step |
| ext_in | input | 1 | External count input, asynchronous |
| gate_in | input | 1 | Gate input, asynchronous |
| idle | input | 1 | Idle-mode indication |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data, combinational from the address |
| irq_lo | output | 1 | Lower-half flag |
| irq_hi | output | 1 | Upper-half flag, also the paired-mode flag |

## Verification
The bench builds the block with HALF_W at 16 and SYNC_STAGES at 2. It keeps the clock-enable low except for counted bursts, so every expected count is an exact number of steps. The period registers are set to small values, which makes the 16-bit and 32-bit wrap points reachable within a few steps. Preloading the count near 0xFFFF through the holding register makes the carry into the upper half and a stale snapshot reachable.

// File: rtl/tpair_pkg.sv
package tpair_pkg;

    localparam int PRE_W = 8;

    localparam logic [2:0] A_CTL_LO = 3'd0;
    localparam logic [2:0] A_CTL_HI = 3'd1;
    localparam logic [2:0] A_CNT_LO = 3'd2;
    localparam logic [2:0] A_CNT_HI = 3'd3;
    localparam logic [2:0] A_PER_LO = 3'd4;
    localparam logic [2:0] A_PER_HI = 3'd5;
    localparam logic [2:0] A_HOLD   = 3'd6;
    localparam logic [2:0] A_FLAGS  = 3'd7;

    typedef enum logic [1:0] {
        DIV1   = 2'd0,
        DIV8   = 2'd1,
        DIV64  = 2'd2,
        DIV256 = 2'd3
    } div_e;

    typedef struct packed {
        logic run;
        logic gate_en;
        logic istop;
        div_e div;
        logic pair;
        logic ext_src;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [7:0] raw);
        ctrl_t c;
        c.run     = raw[7];
        c.gate_en = raw[6];
        c.istop   = raw[5];
        c.div     = div_e'(raw[4:3]);
        c.pair    = raw[2];
        c.ext_src = raw[1];
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] div_last(input div_e d);
        case (d)
            DIV1:    return PRE_W'(0);
            DIV8:    return PRE_W'(7);
            DIV64:   return PRE_W'(63);
            default: return PRE_W'(255);
        endcase
    endfunction

    function automatic logic is_gated(input ctrl_t c);
        return c.gate_en && !c.ext_src;
    endfunction

endpackage

// File: rtl/tpair_sync.sv
module tpair_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= din;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall  = !chain_q[STAGES-1] && chain_q[STAGES];
endmodule

// File: rtl/tpair_step.sv
module tpair_step
    import tpair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  logic  tick,
    input  logic  ext_rise,
    input  logic  gate_lvl,
    input  logic  gate_fall,
    input  logic  idle,
    input  logic  clr,
    output logic  step,
    output logic  gate_done
);
    logic [PRE_W-1:0] pre_q;
    logic live, src, hit, at_last;

    assign live    = ctl.run && !(ctl.istop && idle);
    assign src     = ctl.ext_src ? ext_rise : (ctl.gate_en ? (tick && gate_lvl) : tick);
    assign hit     = live && src;
    assign at_last = (pre_q == div_last(ctl.div));

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (hit)    pre_q <= at_last ? '0 : pre_q + 1'b1;
    end

    assign step      = hit && at_last;
    assign gate_done = ctl.run && is_gated(ctl) && gate_fall;
endmodule

// File: rtl/tpair_timer.sv
module tpair_timer
    import tpair_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ext_in,
    input  logic              gate_in,
    input  logic              idle,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [2:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int FULL_W = 2 * HALF_W;

    logic [7:0]        ctrl_lo_q, ctrl_hi_q;
    logic [HALF_W-1:0] cnt_lo_q, cnt_hi_q, per_lo_q, per_hi_q, hold_q;
    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic              flag_lo_q, flag_hi_q;

    ctrl_t cl, ch;
    ctrl_t ctl_v [2];
    logic  paired;
    logic  [1:0] step_v, gdone_v;

    logic ext_lvl, ext_rise, ext_fall;
    logic gate_lvl, gate_rise, gate_fall;

    logic wr_ctl_lo, wr_ctl_hi, wr_cnt_lo, wr_cnt_hi, wr_per_lo, wr_per_hi;
    logic wr_hold, wr_flags, rd_cnt_lo, pre_clr;
    logic match32, match_lo, match_hi, set_lo, set_hi;
    logic [FULL_W-1:0] full_cnt, full_per;

    assign cl       = ctrl_decode(ctrl_lo_q);
    assign ch       = ctrl_decode(ctrl_hi_q);
    assign paired   = cl.pair;
    assign ctl_v[0] = cl;
    assign ctl_v[1] = ch;

    assign wr_ctl_lo = bus_we && bus_addr == A_CTL_LO;
    assign wr_ctl_hi = bus_we && bus_addr == A_CTL_HI;
    assign wr_cnt_lo = bus_we && bus_addr == A_CNT_LO;
    assign wr_cnt_hi = bus_we && bus_addr == A_CNT_HI;
    assign wr_per_lo = bus_we && bus_addr == A_PER_LO;
    assign wr_per_hi = bus_we && bus_addr == A_PER_HI;
    assign wr_hold   = bus_we && bus_addr == A_HOLD;
    assign wr_flags  = bus_we && bus_addr == A_FLAGS;
    assign rd_cnt_lo = bus_re && bus_addr == A_CNT_LO;
    assign pre_clr   = wr_ctl_lo || wr_ctl_hi || wr_cnt_lo || wr_cnt_hi;

    tpair_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_in),
        .level(ext_lvl), .rise(ext_rise), .fall(ext_fall)
    );

    tpair_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst(rst), .din(gate_in),
        .level(gate_lvl), .rise(gate_rise), .fall(gate_fall)
    );

    for (genvar i = 0; i < 2; i++) begin : g_half
        tpair_step u_step (
            .clk(clk), .rst(rst), .ctl(ctl_v[i]), .tick(tick),
            .ext_rise(ext_rise), .gate_lvl(gate_lvl), .gate_fall(gate_fall),
            .idle(idle), .clr(pre_clr),
            .step(step_v[i]), .gate_done(gdone_v[i])
        );
    end

    assign full_cnt = {cnt_hi_q, cnt_lo_q};
    assign full_per = {per_hi_q, per_lo_q};
    assign match32  = step_v[0] && full_cnt == full_per;
    assign match_lo = step_v[0] && cnt_lo_q == per_lo_q;
    assign match_hi = step_v[1] && cnt_hi_q == per_hi_q;

    always_comb begin
        nxt_lo = cnt_lo_q;
        nxt_hi = cnt_hi_q;
        if (paired) begin
            if (wr_cnt_lo) begin
                nxt_lo = bus_wdata;
                nxt_hi = hold_q;
            end else if (wr_cnt_hi) begin
                nxt_hi = bus_wdata;
            end else if (step_v[0]) begin
                {nxt_hi, nxt_lo} = match32 ? '0 : full_cnt + 1'b1;
            end
        end else begin
            if (wr_cnt_lo)      nxt_lo = bus_wdata;
            else if (step_v[0]) nxt_lo = match_lo ? '0 : cnt_lo_q + 1'b1;
            if (wr_cnt_hi)      nxt_hi = bus_wdata;
            else if (step_v[1]) nxt_hi = match_hi ? '0 : cnt_hi_q + 1'b1;
        end
    end

    always_comb begin
        if (paired) begin
            set_lo = 1'b0;
            set_hi = is_gated(cl) ? gdone_v[0] : match32;
        end else begin
            set_lo = is_gated(cl) ? gdone_v[0] : match_lo;
            set_hi = is_gated(ch) ? gdone_v[1] : match_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_lo_q <= '0;
            ctrl_hi_q <= '0;
            cnt_lo_q  <= '0;
            cnt_hi_q  <= '0;
            per_lo_q  <= '1;
            per_hi_q  <= '1;
            hold_q    <= '0;
            flag_lo_q <= 1'b0;
            flag_hi_q <= 1'b0;
        end else begin
            if (wr_ctl_lo) ctrl_lo_q <= bus_wdata[7:0];
            if (wr_ctl_hi) ctrl_hi_q <= bus_wdata[7:0];
            if (wr_per_lo) per_lo_q  <= bus_wdata;
            if (wr_per_hi) per_hi_q  <= bus_wdata;
            cnt_lo_q <= nxt_lo;
            cnt_hi_q <= nxt_hi;
            if (paired) begin
                if (wr_hold)        hold_q <= bus_wdata;
                else if (rd_cnt_lo) hold_q <= cnt_hi_q;
            end
            flag_lo_q <= set_lo || (flag_lo_q && !(wr_flags && bus_wdata[0]));
            flag_hi_q <= set_hi || (flag_hi_q && !(wr_flags && bus_wdata[1]));
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTL_LO: bus_rdata = HALF_W'(ctrl_lo_q);
            A_CTL_HI: bus_rdata = HALF_W'(ctrl_hi_q);
            A_CNT_LO: bus_rdata = cnt_lo_q;
            A_CNT_HI: bus_rdata = cnt_hi_q;
            A_PER_LO: bus_rdata = per_lo_q;
            A_PER_HI: bus_rdata = per_hi_q;
            A_HOLD:   bus_rdata = hold_q;
            default:  bus_rdata = HALF_W'({flag_hi_q, flag_lo_q});
        endcase
    end

    assign irq_lo = flag_lo_q;
    assign irq_hi = flag_hi_q;
endmodule

// File: rtl/tpair_timer_chk.sv
module tpair_timer_chk
    import tpair_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              idle,
    input logic              bus_we,
    input logic              bus_re,
    input logic [2:0]        bus_addr,
    input logic [HALF_W-1:0] bus_wdata,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [7:0]        ctrl_lo,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] per_lo,
    input logic [HALF_W-1:0] per_hi,
    input logic [HALF_W-1:0] hold,
    input logic              step_lo
);
    ctrl_t c;
    assign c = ctrl_decode(ctrl_lo);

    // R5
    wrap32_chk: assert property (@(posedge clk) disable iff (rst)
        c.pair && step_lo && !bus_we && {cnt_hi, cnt_lo} == {per_hi, per_lo}
        |=> cnt_hi == '0 && cnt_lo == '0);

    // R5
    lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        c.pair && !irq_lo |=> !irq_lo);

    // R6
    snap_chk: assert property (@(posedge clk) disable iff (rst)
        c.pair && bus_re && !bus_we && bus_addr == A_CNT_LO
        |=> hold == $past(cnt_hi));

    // R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        c.pair && bus_we && bus_addr == A_CNT_LO
        |=> cnt_hi == $past(hold) && cnt_lo == $past(bus_wdata));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        c.run && c.istop && idle && !bus_we |=> $stable(cnt_lo));

    // R13
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hi && !(bus_we && bus_addr == A_FLAGS && bus_wdata[1]) |=> irq_hi);
endmodule

bind tpair_timer tpair_timer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .idle(idle),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi),
    .ctrl_lo(ctrl_lo_q), .cnt_lo(cnt_lo_q), .cnt_hi(cnt_hi_q),
    .per_lo(per_lo_q), .per_hi(per_hi_q), .hold(hold_q),
    .step_lo(step_v[0])
);

// File: tb/tpair_timer_test.sv
module tpair_timer_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0, ext_in = 1'b0, gate_in = 1'b0, idle = 1'b0;
    logic         bus_we = 1'b0, bus_re = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0]   addr;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t exp_q[$];
    event  smp;

    always #5 clk = ~clk;

    tpair_timer #(.HALF_W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .tick(tick), .ext_in(ext_in), .gate_in(gate_in),
        .idle(idle), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // monitor: pops expected items and compares read data
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %0d actual %h expected %h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic tk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        #2 -> smp;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, 16'h0000, "R1 ctrl_lo");
        rd(3'd2, 16'h0000, "R1 cnt_lo");
        rd(3'd3, 16'h0000, "R1 cnt_hi");
        rd(3'd4, 16'hFFFF, "R1 per_lo");
        rd(3'd6, 16'h0000, "R1 hold");
        rd(3'd7, 16'h0000, "R1 flags");
        pin(irq_hi, 1'b0, "R1 irq_hi");

        // R2 independent halves
        wr(3'd4, 16'd4, 1'b0);
        wr(3'd1, 16'h0080, 1'b0);
        wr(3'd0, 16'h0080, 1'b0);
        ticks(7);
        rd(3'd2, 16'd2, "R2 lo wrap");
        rd(3'd3, 16'd7, "R2 hi count");
        rd(3'd7, 16'h0001, "R2 lo flag only");

        // R13 clear and set priority
        wr(3'd7, 16'h0001, 1'b0);
        rd(3'd7, 16'h0000, "R13 w1c");
        wr(3'd2, 16'd4, 1'b0);
        wr(3'd7, 16'h0001, 1'b1);
        rd(3'd7, 16'h0001, "R13 set beats clear");
        wr(3'd7, 16'h0003, 1'b0);

        // R7 paired load via hold
        wr(3'd0, 16'h0000, 1'b0);
        wr(3'd1, 16'h0000, 1'b0);
        wr(3'd4, 16'hFFFF, 1'b0);
        wr(3'd5, 16'hFFFF, 1'b0);
        wr(3'd0, 16'h0004, 1'b0);
        wr(3'd6, 16'h0012, 1'b0);
        wr(3'd2, 16'hFFFE, 1'b0);
        rd(3'd3, 16'h0012, "R7 hi from hold");
        rd(3'd2, 16'hFFFE, "R7 lo written");

        // R3 carry, R4 upper control ignored (upper run clear)
        wr(3'd0, 16'h0084, 1'b0);
        ticks(3);
        rd(3'd2, 16'h0001, "R3 lo after carry");
        rd(3'd6, 16'h0013, "R6 snapshot");
        rd(3'd3, 16'h0013, "R3 hi carried");

        // R6 stale snapshot
        wr(3'd6, 16'h0020, 1'b0);
        wr(3'd2, 16'hFFFF, 1'b0);
        rd(3'd2, 16'hFFFF, "R6 read lo");
        ticks(1);
        rd(3'd6, 16'h0020, "R6 snapshot kept");
        rd(3'd3, 16'h0021, "R3 hi advanced");
        rd(3'd7, 16'h0000, "R5 no flag before match");

        // R5 combined period match
        wr(3'd5, 16'h0021, 1'b0);
        wr(3'd4, 16'h0002, 1'b0);
        ticks(4);
        rd(3'd2, 16'h0001, "R5 lo after wrap");
        rd(3'd3, 16'h0000, "R5 hi after wrap");
        rd(3'd7, 16'h0002, "R5 upper flag only");
        pin(irq_hi, 1'b1, "R5 irq_hi");

        // R4 upper control write with slow divider has no effect
        wr(3'd1, 16'h0098, 1'b0);
        ticks(2);
        rd(3'd2, 16'h0003, "R4 lower still governs");
        wr(3'd1, 16'h0000, 1'b0);

        // R8 unpaired hold inactive
        wr(3'd7, 16'h0003, 1'b0);
        wr(3'd0, 16'h0080, 1'b0);
        wr(3'd6, 16'h0055, 1'b0);
        wr(3'd3, 16'h0007, 1'b0);
        wr(3'd2, 16'h0003, 1'b0);
        rd(3'd3, 16'h0007, "R8 hi untouched");
        rd(3'd2, 16'h0003, "R8 lo written");
        rd(3'd6, 16'h0000, "R8 hold unchanged");

        // R11 idle
        wr(3'd4, 16'hFFFF, 1'b0);
        wr(3'd0, 16'h00A0, 1'b0);
        wr(3'd2, 16'h0000, 1'b0);
        idle = 1'b1;
        ticks(5);
        rd(3'd2, 16'h0000, "R11 frozen in idle");
        idle = 1'b0;
        ticks(3);
        rd(3'd2, 16'h0003, "R11 resumes");
        wr(3'd0, 16'h0080, 1'b0);
        idle = 1'b1;
        ticks(4);
        rd(3'd2, 16'h0007, "R11 runs through idle");
        idle = 1'b0;

        // R12 prescaler
        wr(3'd0, 16'h0088, 1'b0);
        wr(3'd2, 16'h0000, 1'b0);
        ticks(20);
        rd(3'd2, 16'h0002, "R12 divide 8");
        wr(3'd0, 16'h0088, 1'b0);
        ticks(4);
        rd(3'd2, 16'h0002, "R12 cleared by write");
        ticks(4);
        rd(3'd2, 16'h0003, "R12 step after clear");

        // R9 external source
        wr(3'd0, 16'h0082, 1'b0);
        wr(3'd2, 16'h0000, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_in = 1'b1;
            @(negedge clk);
            @(negedge clk); ext_in = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(3'd2, 16'h0005, "R9 external edges");
        ticks(3);
        rd(3'd2, 16'h0005, "R9 tick ignored");

        // R10 gated accumulation
        wr(3'd7, 16'h0003, 1'b0);
        wr(3'd0, 16'h00C0, 1'b0);
        wr(3'd2, 16'h0000, 1'b0);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        gate_in = 1'b1;
        repeat (6) @(negedge clk);
        gate_in = 1'b0;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        rd(3'd2, 16'h0006, "R10 gated count");
        rd(3'd7, 16'h0001, "R10 fall flag");
        pin(irq_lo, 1'b1, "R10 irq_lo");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule